// File: doc/BRIEF.md
# Stereo Soft Mute with Silence Detection

This block sits in the digital path of a two-channel audio converter, between the serial receiver and the interpolation filter. Each time the sample strobe is high it takes one signed left sample and one signed right sample, multiplies both by a shared linear gain and registers the result. When the mute input is held high the gain walks down by one step per sample period until the output is silent. When mute is released it walks back up to full scale. A change of the mute input part-way through a ramp simply reverses the direction from the gain value reached so far, so there is never a jump in level.

In parallel, the block watches the incoming samples for a long stretch of digital silence. After a run of consecutive sample periods in which both channels are exactly zero, it raises a silence flag that downstream logic can use to switch off an output stage. The flag drops after the first sample period that carries any non-zero bit on either channel.

The gain is a `GAIN_W`-bit unsigned coefficient. With the default of 10 bits a full ramp takes 1023 sample periods. The silence run length is `ZERO_RUN`, 8192 by default.

Top module: `soft_mute_zdet`

## Requirements
- R1: While `rst` is high at a rising clock edge, the gain becomes full scale (2^GAIN_W-1), the silence run count is cleared, and `zero_flag`, `out_vld`, `out_l` and `out_r` are 0 after that edge.
- R2: `out_vld` is 1 for exactly the one clock that follows a clock with `smp_vld` high, and `out_l`/`out_r` take their new values in that same clock.
- R3: For each strobe with `mute_req` high, the gain used for the next strobe is one lower, stopping at 0. At gain 0 both outputs are exactly 0.
- R4: For each strobe with `mute_req` low, the gain used for the next strobe is one higher, stopping at full scale.
- R5: A change of `mute_req` during a ramp reverses the ramp from the current gain value, with no jump in gain.
- R6: At full-scale gain each output equals its input sample bit for bit.
- R7: Below full scale each output is floor(sample * gain / 2^GAIN_W), with the sample read as two's complement. The sample is scaled by the gain value in force before that strobe's step.
- R8: `zero_flag` rises in the clock after the strobe that completes a run of `ZERO_RUN` consecutive strobes in which both channels are all zero. It stays high while further all-zero strobes arrive.
- R9: A strobe with any non-zero bit on either channel clears `zero_flag` in the next clock and restarts the run count from zero.
- R10: Clocks without a strobe change neither the gain, the outputs, the run count nor `zero_flag`, whatever `mute_req` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe, one clock per sample period |
| smp_l | input | DATA_W | Left input sample, two's complement |
| smp_r | input | DATA_W | Right input sample, two's complement |
| mute_req | input | 1 | 1 ramps the gain toward silence, 0 ramps it toward full scale |
| out_vld | output | 1 | Output strobe, one clock after `smp_vld` |
| out_l | output | DATA_W | Scaled left sample, held between strobes |
| out_r | output | DATA_W | Scaled right sample, held between strobes |
| zero_flag | output | 1 | High after a long run of all-zero stereo samples |

## Verification
The bench builds the block with `DATA_W`=8, `GAIN_W`=4 and `ZERO_RUN`=8. With these values a full ramp is 15 strobes and a silence run is 8 strobes. Thousands of strobes then sweep every 8-bit sample value through every gain step, including many ramp reversals. The narrow sample width also makes the floor rounding of negative products show on almost every value. The short run length lets the bench hit the silence threshold exactly and break runs on either channel at every position.

// File: rtl/smz_pkg.sv
package smz_pkg;

    // Direction the shared gain moves at a sample strobe.
    typedef enum logic [1:0] {
        RAMP_HOLD = 2'd0,
        RAMP_DOWN = 2'd1,
        RAMP_UP   = 2'd2
    } ramp_dir_e;

    // Per-channel index for the generated datapath.
    typedef enum logic {
        CH_LEFT  = 1'b0,
        CH_RIGHT = 1'b1
    } chan_e;

    localparam int NUM_CH = 2;

    // Pick the ramp direction from the mute request and the gain limits.
    function automatic ramp_dir_e pick_dir(input logic mute,
                                           input logic at_floor,
                                           input logic at_top);
        ramp_dir_e d;
        if (mute) begin
            d = at_floor ? RAMP_HOLD : RAMP_DOWN;
        end else begin
            d = at_top ? RAMP_HOLD : RAMP_UP;
        end
        return d;
    endfunction

endpackage

// File: rtl/smz_gain_ramp.sv
module smz_gain_ramp
    import smz_pkg::*;
#(
    parameter int GAIN_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              mute,
    output logic [GAIN_W-1:0] gain,
    output logic              at_top
);
    localparam logic [GAIN_W-1:0] GAIN_MAX = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] GAIN_ONE = GAIN_W'(1);

    logic      at_floor;
    ramp_dir_e dir;

    assign at_top   = (gain == GAIN_MAX);
    assign at_floor = (gain == '0);
    assign dir      = pick_dir(mute, at_floor, at_top);

    always_ff @(posedge clk) begin
        if (rst) begin
            gain <= GAIN_MAX;
        end else if (step) begin
            unique case (dir)
                RAMP_DOWN: gain <= gain - GAIN_ONE;
                RAMP_UP:   gain <= gain + GAIN_ONE;
                default:   gain <= gain;
            endcase
        end
    end

endmodule

// File: rtl/smz_chan_scaler.sv
module smz_chan_scaler #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic [GAIN_W-1:0] gain,
    input  logic              full,
    output logic [DATA_W-1:0] dout
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic        [DATA_W-1:0] scaled;

    always_comb begin
        prod    = $signed(din) * $signed({1'b0, gain});
        shifted = prod >>> GAIN_W;
        scaled  = shifted[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
        end else if (load) begin
            dout <= full ? din : scaled;
        end
    end

endmodule

// File: rtl/smz_zero_run.sv
module smz_zero_run #(
    parameter int DATA_W   = 24,
    parameter int ZERO_RUN = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [DATA_W-1:0] din_l,
    input  logic [DATA_W-1:0] din_r,
    output logic              flag
);
    localparam int              CNT_W   = $clog2(ZERO_RUN + 1);
    localparam logic [CNT_W-1:0] RUN_CNT = CNT_W'(ZERO_RUN);

    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] cnt_next;
    logic             silent;

    assign silent = (din_l == '0) && (din_r == '0);

    always_comb begin
        if (!silent) begin
            cnt_next = '0;
        end else if (run_cnt == RUN_CNT) begin
            cnt_next = run_cnt;
        end else begin
            cnt_next = run_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            flag    <= 1'b0;
        end else if (step) begin
            run_cnt <= cnt_next;
            flag    <= (cnt_next == RUN_CNT);
        end
    end

endmodule

// File: rtl/soft_mute_zdet.sv
module soft_mute_zdet
    import smz_pkg::*;
#(
    parameter int DATA_W   = 24,
    parameter int GAIN_W   = 10,
    parameter int ZERO_RUN = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [DATA_W-1:0] smp_l,
    input  logic [DATA_W-1:0] smp_r,
    input  logic              mute_req,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r,
    output logic              zero_flag
);
    logic [GAIN_W-1:0] gain;
    logic              gain_full;
    logic [DATA_W-1:0] ch_in  [NUM_CH];
    logic [DATA_W-1:0] ch_out [NUM_CH];

    assign ch_in[CH_LEFT]  = smp_l;
    assign ch_in[CH_RIGHT] = smp_r;
    assign out_l = ch_out[CH_LEFT];
    assign out_r = ch_out[CH_RIGHT];

    smz_gain_ramp #(.GAIN_W(GAIN_W)) i_ramp (
        .clk    (clk),
        .rst    (rst),
        .step   (smp_vld),
        .mute   (mute_req),
        .gain   (gain),
        .at_top (gain_full)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        smz_chan_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_scale (
            .clk  (clk),
            .rst  (rst),
            .load (smp_vld),
            .din  (ch_in[c]),
            .gain (gain),
            .full (gain_full),
            .dout (ch_out[c])
        );
    end

    smz_zero_run #(.DATA_W(DATA_W), .ZERO_RUN(ZERO_RUN)) i_zrun (
        .clk   (clk),
        .rst   (rst),
        .step  (smp_vld),
        .din_l (smp_l),
        .din_r (smp_r),
        .flag  (zero_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= smp_vld;
        end
    end

endmodule

// File: rtl/smz_chk.sv
module smz_chk #(
    parameter int DATA_W = 24,
    parameter int GAIN_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_vld,
    input logic [DATA_W-1:0] smp_l,
    input logic [DATA_W-1:0] smp_r,
    input logic              mute_req,
    input logic              out_vld,
    input logic [DATA_W-1:0] out_l,
    input logic [DATA_W-1:0] out_r,
    input logic              zero_flag,
    input logic [GAIN_W-1:0] gain
);
    localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};
    localparam logic [GAIN_W-1:0] GONE = GAIN_W'(1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (gain == GMAX && !zero_flag && !out_vld));

    // R2
    out_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        smp_vld |=> out_vld);

    // R2
    out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> !out_vld);

    // R3
    ramp_down_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && mute_req && gain != '0) |=> (gain == $past(gain) - GONE));

    // R4
    ramp_up_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && !mute_req && gain != GMAX) |=> (gain == $past(gain) + GONE));

    // R3
    silent_out_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && gain == '0) |=> (out_l == '0 && out_r == '0));

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && gain == GMAX) |=> (out_l == $past(smp_l) && out_r == $past(smp_r)));

    // R8
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_flag) |-> $past(smp_vld && smp_l == '0 && smp_r == '0));

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_vld && (smp_l != '0 || smp_r != '0)) |=> !zero_flag);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_vld |=> ($stable(gain) && $stable(out_l) && $stable(out_r) && $stable(zero_flag)));

endmodule

bind soft_mute_zdet smz_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) i_chk (.*);

// File: tb/test_soft_mute_zdet.sv
module test_soft_mute_zdet;
    localparam int DW   = 8;
    localparam int GW   = 4;
    localparam int ZR   = 8;
    localparam int GMAX = (1 << GW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          smp_vld = 1'b0;
    logic [DW-1:0] smp_l = '0;
    logic [DW-1:0] smp_r = '0;
    logic          mute_req = 1'b0;
    logic          out_vld;
    logic [DW-1:0] out_l;
    logic [DW-1:0] out_r;
    logic          zero_flag;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    int  mg;      // model gain
    int  zc;      // model zero run

    always #5 clk = ~clk;

    soft_mute_zdet #(.DATA_W(DW), .GAIN_W(GW), .ZERO_RUN(ZR)) i_soft_mute_zdet (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_l(smp_l), .smp_r(smp_r),
        .mute_req(mute_req), .out_vld(out_vld), .out_l(out_l), .out_r(out_r),
        .zero_flag(zero_flag)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int scale(input logic [DW-1:0] x, input int g);
        int xs;
        xs = int'($signed(x));
        if (g == GMAX) return xs;
        return (xs * g) >>> GW;
    endfunction

    // One strobe, then check outputs in the following clock.
    task automatic send(input logic [DW-1:0] l, input logic [DW-1:0] r,
                        input logic m, input string tag_in);
        string tg, tz;
        int el, er;
        tg = tag_in;
        if (tg == "") tg = (mg == GMAX) ? "R6" : ((mg == 0) ? "R3" : "R7");
        el = scale(l, mg);
        er = scale(r, mg);
        if (l == '0 && r == '0) begin
            zc = (zc < ZR) ? zc + 1 : ZR;
            tz = "R8";
        end else begin
            zc = 0;
            tz = "R9";
        end
        @(negedge clk);
        smp_vld = 1'b1; smp_l = l; smp_r = r; mute_req = m;
        @(negedge clk);
        smp_vld = 1'b0;
        check("R2", "out_vld", int'(out_vld), 1);
        check(tg, "out_l", int'($signed(out_l)), el);
        check(tg, "out_r", int'($signed(out_r)), er);
        check(tz, "zero_flag", int'(zero_flag), (zc == ZR) ? 1 : 0);
        if (m) mg = (mg > 0) ? mg - 1 : 0;
        else   mg = (mg < GMAX) ? mg + 1 : GMAX;
        @(negedge clk);
        check("R2", "out_vld low", int'(out_vld), 0);
    endtask

    initial begin
        mg = GMAX;
        zc = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "out_vld", int'(out_vld), 0);
        check("R1", "out_l", int'(out_l), 0);
        check("R1", "out_r", int'(out_r), 0);
        check("R1", "zero_flag", int'(zero_flag), 0);
        send(8'h7F, 8'h80, 1'b0, "R1");

        // R3 full ramp down, then silence holds
        for (int i = 0; i < GMAX + 3; i++) send(8'h7F, 8'h81, 1'b1, "R3");
        // R4 full ramp back up
        for (int i = 0; i < GMAX + 2; i++) send(8'h64, 8'h9C, 1'b0, "R4");
        // R5 reverse mid ramp
        for (int i = 0; i < 6; i++) send(8'h55, 8'hAB, 1'b1, "R5");
        for (int i = 0; i < 9; i++) send(8'h55, 8'hAB, 1'b0, "R5");

        // R10 idle clocks with mute toggling change nothing
        begin
            logic [DW-1:0] hl, hr;
            hl = out_l; hr = out_r;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                mute_req = i[0];
            end
            check("R10", "out_l held", int'(out_l), int'(hl));
            check("R10", "out_r held", int'(out_r), int'(hr));
            send(8'hC3, 8'h3C, 1'b0, "R10");
        end

        // Sweep: every sample value across many gains and reversals
        for (int i = 0; i < 4096; i++) begin
            logic [DW-1:0] a, b;
            a = DW'(i);
            b = DW'(i * 37 + i / 256);
            send(a, b, ((i / 23) % 2) == 1, "");
        end

        // R8 silence threshold exactly
        for (int i = 0; i < ZR + 3; i++) send('0, '0, 1'b0, "");
        // R9 break on left, then on right at every position
        send(8'h01, '0, 1'b0, "R9");
        for (int p = 0; p < ZR; p++) begin
            for (int i = 0; i < p; i++) send('0, '0, 1'b0, "");
            send('0, 8'h80, 1'b0, "R9");
        end
        for (int i = 0; i < ZR; i++) send('0, '0, 1'b0, "");
        send('0, 8'h01, 1'b1, "R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule